// File: doc/BRIEF.md
# Second-Order Sinc Decimation Filter

This block turns the one-bit stream of an oversampling sigma-delta modulator into an 8-bit conversion result at a lower rate. Each input bit counts as 0 or 1. Two cascaded integrators accumulate the stream on every modulator clock. A pair of differencing stages runs once per output sample. Together they form a second-order sinc (cascaded integrator-comb) low-pass filter with unity DC gain. The filter removes the shaped quantization noise and the images above the signal band, and it lowers the sample rate by the selected oversampling ratio.

The ratio is picked from four values on a two-bit select. A larger ratio gives a slower output rate and a finer result. The filter sum spans 0 to OSR². A right shift rescales it to an offset-binary code centred on 128, so code n stands for an input of (n − 128)/128 of the reference. The top of the range is clamped to 255. The integrators and differencing registers wrap modulo their width. Integrator overflow therefore cancels in the differences. After a reset, or after a new ratio is selected, the first two decimation instants produce no strobe, because the differencing delays do not yet hold real samples.

Top module: `sinc2_decimator`

## Requirements
- R1: While reset is asserted, and until the first strobe, `result_valid` is 0 and `result` reads 128.
- R2: `ratio_sel` selects the oversampling ratio R: 0 gives 32, 1 gives 64, 2 gives 128 and 3 gives 256. After reset the block starts with R = 64. Consecutive strobes under one setting are exactly R clock cycles apart.
- R3: `result_valid` is a single-cycle pulse, high only in the cycle after a decimation instant, never on two adjacent cycles.
- R4: Counting rising edges from 1 after reset release with `ratio_sel` = 1 held, the first strobe follows edge 3·64. After a ratio change is registered on some edge, the first strobe follows the 3·R-th edge after it. The two earlier decimation instants give no strobe.
- R5: A strobe that follows edge index e (counted from 0 after reset release) carries min(255, S >> (2·log2 R − 8)). Here S = Σ w(k)·x[e−1−k] for k = 1..2R−1, with weight w(k) = min(k, 2R−k). x[i] is the bit sampled on edge i, and x is 0 before reset release.
- R6: A steady all-zero input gives code 0. A steady all-one input gives code 255, clamped from 256. A steady alternating input gives code 128.
- R7: When a ratio change lands on the same edge as a decimation instant, the change takes precedence. No strobe follows that edge, and the schedule restarts as in R4.
- R8: The integrators keep running across ratio changes and wrap modulo their width. Results stay exact over arbitrarily long runs, including long all-one runs that overflow the integrators many times.
- R9: `result` changes only in a cycle where `result_valid` is high, and holds its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_in | input | 1 | One-bit modulator output, sampled on each rising edge |
| ratio_sel | input | 2 | Oversampling ratio select (0:32, 1:64, 2:128, 3:256) |
| result | output | 8 | Offset-binary conversion result, 128 = zero input |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
A ratio change and a decimation instant can fall on the same clock edge. The bench provokes this by predicting the next decimation edge from its own schedule model and changing `ratio_sel` just before that edge, after enough instants have passed that a strobe would otherwise be due. It judges the outcome in three ways: no strobe may follow that edge, the next three instants must follow the new ratio's period, and only the third of them may strobe. That third value must match the triangular-weight sum computed over the bench's own record of input bits.

// File: rtl/sinc2_pkg.sv
`timescale 1ns/1ps
package sinc2_pkg;

  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    RATIO_32  = 2'd0,
    RATIO_64  = 2'd1,
    RATIO_128 = 2'd2,
    RATIO_256 = 2'd3
  } ratio_e;

  // log2 of the oversampling ratio for a given select code
  function automatic int osr_log2(input int min_log2, input logic [SEL_W-1:0] sel);
    return min_log2 + int'(sel);
  endfunction

endpackage

// File: rtl/sinc2_rate_ctrl.sv
`timescale 1ns/1ps
module sinc2_rate_ctrl
  import sinc2_pkg::*;
#(
  parameter int             MIN_LOG2 = 5,
  parameter int             CNT_W    = 8,
  parameter logic [SEL_W-1:0] DEF_SEL = RATIO_64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic [SEL_W-1:0] ratio_q,
  output logic             chg,
  output logic             tick,
  output logic             emit
);

  localparam int PRIME_W = 2;
  localparam logic [PRIME_W-1:0] PRIMED = PRIME_W'(2);

  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] s);
    return CNT_W'((1 << osr_log2(MIN_LOG2, s)) - 1);
  endfunction

  localparam logic [CNT_W-1:0] DEF_LAST = CNT_W'((1 << (MIN_LOG2 + int'(DEF_SEL))) - 1);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SEL_W-1:0]   ratio_d;
  logic [PRIME_W-1:0] prime_q, prime_d;
  logic [CNT_W-1:0]   period_last;

  assign period_last = last_count(ratio_q);
  assign chg         = (ratio_sel != ratio_q);
  assign tick        = !chg && (cnt_q == '0);
  assign emit        = tick && (prime_q == PRIMED);

  // next-state
  always_comb begin
    ratio_d = ratio_q;
    cnt_d   = cnt_q - 1'b1;
    prime_d = prime_q;
    if (chg) begin
      ratio_d = ratio_sel;
      cnt_d   = last_count(ratio_sel);
      prime_d = '0;
    end else if (tick) begin
      cnt_d = period_last;
      if (prime_q != PRIMED) prime_d = prime_q + 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_q <= DEF_SEL;
      cnt_q   <= DEF_LAST;
      prime_q <= '0;
    end else begin
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      prime_q <= prime_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period_last) else $error("down-counter beyond period"); // R3

endmodule

// File: rtl/sinc2_integ.sv
`timescale 1ns/1ps
module sinc2_integ #(
  parameter int W     = 17,
  parameter int ORDER = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  output logic [W-1:0] acc_out
);

  logic [W-1:0] stage_out [ORDER];

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic [W-1:0] acc_q, acc_d, addend;

    if (i == 0) begin : g_first
      assign addend = W'(bit_in);
    end else begin : g_chain
      assign addend = stage_out[i-1];
    end

    // wraps modulo 2^W; overflow cancels in the comb differences
    always_comb acc_d = acc_q + addend;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
    end

    assign stage_out[i] = acc_q;
  end

  assign acc_out = stage_out[ORDER-1];

endmodule

// File: rtl/sinc2_comb.sv
`timescale 1ns/1ps
module sinc2_comb #(
  parameter int W     = 17,
  parameter int ORDER = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] diff [ORDER+1];

  assign diff[0] = din;

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic [W-1:0] dly_q, dly_d;

    always_comb dly_d = en ? diff[i] : dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q <= '0;
      else        dly_q <= dly_d;
    end

    assign diff[i+1] = diff[i] - dly_q;
  end

  assign dout = diff[ORDER];

endmodule

// File: rtl/sinc2_scale.sv
`timescale 1ns/1ps
module sinc2_scale
  import sinc2_pkg::*;
#(
  parameter int W        = 17,
  parameter int ORDER    = 2,
  parameter int OUT_W    = 8,
  parameter int MIN_LOG2 = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             emit,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     sum,
  output logic [OUT_W-1:0] result,
  output logic             result_valid
);

  localparam logic [OUT_W-1:0] MID   = OUT_W'(1 << (OUT_W - 1));
  localparam logic [W-1:0]     TOP_W = W'((1 << OUT_W) - 1);

  logic [W-1:0]     scaled;
  logic [OUT_W-1:0] clamped;
  logic [OUT_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;
  int               shamt;

  always_comb begin
    shamt   = ORDER * osr_log2(MIN_LOG2, sel) - OUT_W;
    scaled  = sum >> shamt;
    clamped = (scaled > TOP_W) ? '1 : scaled[OUT_W-1:0];
    res_d   = emit ? clamped : res_q;
    vld_d   = emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= MID;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;

endmodule

// File: rtl/sinc2_decimator.sv
`timescale 1ns/1ps
module sinc2_decimator
  import sinc2_pkg::*;
#(
  parameter int MIN_LOG2 = 5,
  parameter int ORDER    = 2,
  parameter int OUT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  input  logic [1:0]       ratio_sel,
  output logic [OUT_W-1:0] result,
  output logic             result_valid
);

  localparam int MAX_LOG2 = MIN_LOG2 + (1 << SEL_W) - 1;
  localparam int ACC_W    = ORDER * MAX_LOG2 + 1;
  localparam int CNT_W    = MAX_LOG2;

  logic [SEL_W-1:0] ratio_q;
  logic             chg, tick, emit;
  logic [ACC_W-1:0] integ_out, comb_out, full_scale;

  sinc2_rate_ctrl #(
    .MIN_LOG2 (MIN_LOG2),
    .CNT_W    (CNT_W),
    .DEF_SEL  (RATIO_64)
  ) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .ratio_q   (ratio_q),
    .chg       (chg),
    .tick      (tick),
    .emit      (emit)
  );

  sinc2_integ #(.W(ACC_W), .ORDER(ORDER)) u_integ (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .acc_out (integ_out)
  );

  sinc2_comb #(.W(ACC_W), .ORDER(ORDER)) u_comb (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (tick),
    .din   (integ_out),
    .dout  (comb_out)
  );

  sinc2_scale #(
    .W        (ACC_W),
    .ORDER    (ORDER),
    .OUT_W    (OUT_W),
    .MIN_LOG2 (MIN_LOG2)
  ) u_scale (
    .clk          (clk),
    .rst_n        (rst_n),
    .emit         (emit),
    .sel          (ratio_q),
    .sum          (comb_out),
    .result       (result),
    .result_valid (result_valid)
  );

  assign full_scale = ACC_W'(1) << (ORDER * osr_log2(MIN_LOG2, ratio_q));

  AST_SUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> comb_out <= full_scale) else $error("filter sum above OSR^2"); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid) else $error("strobe longer than one cycle"); // R3

  AST_CHG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !result_valid) else $error("strobe after ratio change"); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (result_valid || $stable(result))) else $error("result moved without strobe"); // R9

endmodule

// File: tb/sim_sinc2_decimator.sv
`timescale 1ns/1ps
module sim_sinc2_decimator;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_in;
  logic [1:0] ratio_sel;
  logic [7:0] result;
  logic       result_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // bench model state
  bit hist [1024];
  int ecnt;
  int m_sel;
  int next_tick;
  int ticks;
  bit exp_valid;
  int exp_res;
  int last_res;
  int prev_v;
  int first_v;
  int ratio_now;
  int seed_dummy;

  always #10 clk = ~clk;

  sinc2_decimator u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_in       (bit_in),
    .ratio_sel    (ratio_sel),
    .result       (result),
    .result_valid (result_valid)
  );

  function automatic int osr(input int s);
    return 32 << s;
  endfunction

  // triangular sinc2 kernel over recorded bits, then shift and clamp (R5)
  function automatic int expect_code(input int e, input int s);
    int r  = osr(s);
    int sm = 0;
    int v;
    for (int k = 1; k < 2 * r; k++) begin
      int idx = e - 1 - k;
      if (idx >= 0) sm += ((k < r) ? k : 2 * r - k) * int'(hist[idx % 1024]);
    end
    v = sm >> (2 * (5 + s) - 8);
    return (v > 255) ? 255 : v;
  endfunction

  task automatic fail(input string tag, input int act, input int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) fail(tag, act, exp);
  endtask

  task automatic model_init();
    for (int i = 0; i < 1024; i++) hist[i] = 1'b0;
    ecnt = 0; m_sel = 1; next_tick = osr(1) - 1; ticks = 0;
    last_res = 128; prev_v = -1; first_v = -1; exp_valid = 1'b0;
  endtask

  task automatic model_edge();
    hist[ecnt % 1024] = bit_in;
    exp_valid = 1'b0;
    if (int'(ratio_sel) != m_sel) begin
      m_sel = int'(ratio_sel);
      next_tick = ecnt + osr(m_sel);
      ticks = 0;
      prev_v = -1;
      first_v = -1;
    end else if (ecnt == next_tick) begin
      ticks++;
      next_tick += osr(m_sel);
      if (ticks >= 3) begin
        exp_valid = 1'b1;
        exp_res   = expect_code(ecnt, m_sel);
      end
    end
    ecnt++;
  endtask

  task automatic compare();
    check("R3 R4 strobe timing", int'(result_valid), int'(exp_valid));
    if (exp_valid && result_valid) check("R5 result value", int'(result), exp_res);
    if (result_valid) begin
      if (prev_v >= 0) check("R2 strobe spacing", ecnt - 1 - prev_v, osr(m_sel));
      prev_v = ecnt - 1;
      if (first_v < 0) first_v = ecnt - 1;
      last_res = int'(result);
    end else begin
      check("R9 hold between strobes", int'(result), last_res);
    end
  endtask

  task automatic step(input logic b);
    bit_in = b;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(input logic [1:0] sel);
    rst_n = 1'b0; bit_in = 1'b0; ratio_sel = 2'd1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(result_valid), 0);
    check("R1 reset result", int'(result), 128);
    ratio_sel = sel;
    rst_n = 1'b1;
    model_init();
  endtask

  task automatic run_random(input int n, input int pct);
    for (int i = 0; i < n; i++) step(($urandom % 100) < pct);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    seed_dummy = $urandom(32'd7741);
    do_reset(2'd1);

    // R6: steady zeros, ones, alternating at R = 64
    for (int i = 0; i < 6 * 64; i++) step(1'b0);
    check("R4 first strobe edge after reset", first_v, 3 * 64 - 1);
    check("R6 all zeros", last_res, 0);
    for (int i = 0; i < 8 * 64; i++) step(1'b1);
    check("R6 all ones clamp", last_res, 255);
    for (int i = 0; i < 6 * 64; i++) step(i[0]);
    check("R6 alternating midscale", last_res, 128);

    // R2 R5: random density under every ratio
    ratio_sel = 2'd0; run_random(12 * 32, 40);
    ratio_sel = 2'd2; run_random(8 * 128, 70);
    ratio_sel = 2'd3; run_random(6 * 256, 20);
    ratio_sel = 2'd1; run_random(5 * 64, 55);

    // R7: change lands on a decimation instant
    while (ecnt != next_tick) step(($urandom % 2) == 1);
    ratio_now = 0;
    ratio_sel = 2'(ratio_now);
    step(1'b1);
    check("R7 no strobe on colliding edge", int'(result_valid), 0);
    run_random(5 * 32, 60);

    // R8: long all-one run wraps the integrators repeatedly
    ratio_sel = 2'd3;
    for (int i = 0; i < 2400; i++) step(1'b1);
    check("R8 exact after integrator wrap", last_res, 255);
    run_random(4 * 256, 35);

    // R4: reset with a non-default select held at release
    do_reset(2'd2);
    run_random(5 * 128, 50);
    check("R4 first strobe after change", first_v, 3 * 128);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule